// File: doc/BRIEF.md
# Start-Done Population Counter

This block reports how many bits are set in an unsigned word. A caller raises `start` for one cycle while the word is on `data_in`, and holds the word there for one more cycle. The block latches the word, clears its tally, and then scans the latched copy one bit per cycle. Each scan cycle adds the lowest bit to the tally and shifts the copy right by one place.

The scan ends as soon as the copy becomes zero, so a word costs one cycle per bit up to and including its highest set bit. It does not always cost the full word width. When the scan ends, the block raises `done` for a single cycle and presents the tally on `count_out`. In every other cycle `count_out` reads zero.

The controller has four states: wait, capture, scan and report. Their encodings are fixed because the datapath enables are decoded from them. Only one request is in flight at a time. While a request runs, the block ignores `start` and `data_in`.

Top module: `popcount_fsmd`

## Requirements
- R1: While `rst_n` is low and right after it, `done` is 0 and `count_out` is 0.
- R2: In the wait state (encoding 00), the block stays there and keeps `done` low for as long as `start` is 0. It never raises `done` without a request.
- R3: A request captures `data_in` on the clock edge after the edge that samples `start` high. The reported `count_out` equals the number of 1 bits in that captured word.
- R4: `done` is high in the cycle that follows 3+n rising edges, counted from the edge that samples `start`. Here n is one plus the index of the highest set bit, or 0 for a zero word. `done` rises only after the scan state (10) has seen the captured copy at zero.
- R5: `done` is high for exactly one cycle per request.
- R6: When `done` is 0, `count_out` is 0.
- R7: A zero word reports a count of 0, with `done` in the cycle after the third edge from `start`. The capture state (01) leaves the tally at 0.
- R8: During capture, scan and report, the block ignores `start` pulses and changes on `data_in`. The capture enable is active only for one cycle after an accepted `start`.
- R9: After the report state (11), the block returns to the wait state unconditionally. A `start` in the very next cycle is accepted.
- R10: An all-ones word reports W, the full word width. This is the largest value the tally holds, and it needs $clog2(W+1) bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled in the wait state |
| data_in | input | W | Word to be counted, captured one edge after `start` |
| done | output | 1 | One-cycle result strobe |
| count_out | output | $clog2(W+1) | Number of set bits while `done` is high, else 0 |

## Verification
A corrupted scan copy or a wrong tally increment shows up at the ports as a wrong `count_out` in the report cycle. A bad shift also moves `done` earlier or later than the 3+n edges the bench predicts. A controller stuck in or skipping a state shows up at once: `done` arrives late or never, stays high for two cycles, or appears with no request queued. A capture that fires twice, or that samples the wrong cycle, shows up when `data_in` is scrambled right after capture and `start` is pulsed mid-scan: the next reported count then disagrees with the expected value queued for that request.

// File: rtl/popcnt_pkg.sv
package popcnt_pkg;
  typedef enum logic [1:0] {
    ST_WAIT    = 2'b00,
    ST_CAPTURE = 2'b01,
    ST_SCAN    = 2'b10,
    ST_REPORT  = 2'b11
  } ctl_state_e;
endpackage

// File: rtl/popcnt_ctrl.sv
module popcnt_ctrl
  import popcnt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       word_zero,
  input  logic       word_lsb,
  output ctl_state_e state,
  output logic       load_en,
  output logic       shift_en,
  output logic       incr_en,
  output logic       show_en
);
  ctl_state_e state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      ST_WAIT:    if (start) state_nx = ST_CAPTURE;
      ST_CAPTURE: state_nx = ST_SCAN;
      ST_SCAN:    if (word_zero) state_nx = ST_REPORT;
      ST_REPORT:  state_nx = ST_WAIT;
      default:    state_nx = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_WAIT;
    else        state <= state_nx;
  end

  // Input-dependent (Mealy) datapath strobes
  always_comb begin
    load_en  = (state == ST_CAPTURE);
    shift_en = (state == ST_SCAN) && !word_zero;
    incr_en  = shift_en && word_lsb;
    show_en  = (state == ST_REPORT);
  end
endmodule

// File: rtl/popcnt_datapath.sv
module popcnt_datapath #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic          shift_en,
  input  logic          incr_en,
  input  logic [W-1:0]  data_in,
  output logic          word_zero,
  output logic          word_lsb,
  output logic [CW-1:0] tally
);
  logic [W-1:0] word_q;
  logic [W-1:0] word_shr;

  function automatic logic [CW-1:0] tally_step(input logic [CW-1:0] t);
    return t + CW'(1);
  endfunction

  // Logical right shift by one, built bit by bit
  for (genvar i = 0; i < W; i++) begin : g_shr
    if (i == W - 1) begin : g_top
      assign word_shr[i] = 1'b0;
    end else begin : g_mid
      assign word_shr[i] = word_q[i+1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      tally  <= '0;
    end else if (load_en) begin
      word_q <= data_in;
      tally  <= '0;
    end else begin
      if (shift_en) word_q <= word_shr;
      if (incr_en)  tally  <= tally_step(tally);
    end
  end

  assign word_zero = (word_q == '0);
  assign word_lsb  = word_q[0];
endmodule

// File: rtl/popcnt_outstage.sv
module popcnt_outstage #(
  parameter int CW = 4
) (
  input  logic          show_en,
  input  logic [CW-1:0] tally,
  output logic          done,
  output logic [CW-1:0] count_out
);
  for (genvar i = 0; i < CW; i++) begin : g_gate
    assign count_out[i] = tally[i] & show_en;
  end
  assign done = show_en;
endmodule

// File: rtl/popcount_fsmd.sv
module popcount_fsmd
  import popcnt_pkg::*;
#(
  parameter int W = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  data_in,
  output logic          done,
  output logic [CW-1:0] count_out
);
  ctl_state_e    state;
  logic          load_en;
  logic          shift_en;
  logic          incr_en;
  logic          show_en;
  logic          word_zero;
  logic          word_lsb;
  logic [CW-1:0] tally;
  logic [1:0]    state_bits;

  assign state_bits = state;

  popcnt_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .word_zero (word_zero),
    .word_lsb  (word_lsb),
    .state     (state),
    .load_en   (load_en),
    .shift_en  (shift_en),
    .incr_en   (incr_en),
    .show_en   (show_en)
  );

  popcnt_datapath #(.W(W), .CW(CW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .shift_en  (shift_en),
    .incr_en   (incr_en),
    .data_in   (data_in),
    .word_zero (word_zero),
    .word_lsb  (word_lsb),
    .tally     (tally)
  );

  popcnt_outstage #(.CW(CW)) u_out (
    .show_en   (show_en),
    .tally     (tally),
    .done      (done),
    .count_out (count_out)
  );
endmodule

// File: rtl/popcnt_checks.sv
module popcnt_checks #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic [CW-1:0] count_out,
  input logic [1:0]    state_bits,
  input logic          load_en,
  input logic          incr_en,
  input logic          word_zero,
  input logic [CW-1:0] tally
);
  assert_idle_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_bits == 2'b00 && !start) |=> (state_bits == 2'b00 && !done));

  assert_tally_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    incr_en |=> (tally == $past(tally) + CW'(1)));

  assert_done_after_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(word_zero));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_out_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (count_out == '0));

  assert_capture_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (tally == '0 && state_bits == 2'b10));

  assert_capture_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> $past(start));

  assert_back_to_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (state_bits == 2'b00));
endmodule

bind popcount_fsmd popcnt_checks #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .done       (done),
  .count_out  (count_out),
  .state_bits (state_bits),
  .load_en    (load_en),
  .incr_en    (incr_en),
  .word_zero  (word_zero),
  .tally      (tally)
);

// File: tb/sim_popcount_fsmd.sv
`timescale 1ns/1ps
module sim_popcount_fsmd;
  localparam int W  = 8;
  localparam int CW = $clog2(W + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  din = '0;
  logic          done;
  logic [CW-1:0] cnt;

  always #4 clk = ~clk;

  popcount_fsmd #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .data_in(din),
    .done(done), .count_out(cnt)
  );

  typedef struct {
    int    exp_cnt;
    int    t0;
    int    exp_lat;
    string tag;
  } item_t;

  item_t sb[$];
  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  bit    prev_done = 1'b0;
  bit    finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ones_in(input logic [W-1:0] w);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(w[i]);
    return n;
  endfunction

  function automatic int span_of(input logic [W-1:0] w);
    int s = 0;
    for (int i = 0; i < W; i++) if (w[i]) s = i + 1;
    return s;
  endfunction

  // Monitor: pops the scoreboard on each result strobe
  always @(negedge clk) begin : mon
    item_t it;
    if (rst_n && !finished) begin
      if (done) begin
        check(!prev_done, "R5", int'(prev_done), 0);
        if (sb.size() == 0) begin
          check(1'b0, "R2/R8 unrequested done", 1, 0);
        end else begin
          it = sb.pop_front();
          check(int'(cnt) == it.exp_cnt, it.tag, int'(cnt), it.exp_cnt);
          check(cyc - it.t0 == it.exp_lat, "R4", cyc - it.t0, it.exp_lat);
        end
      end else begin
        check(cnt == '0, "R6", int'(cnt), 0);
      end
      prev_done <= done;
    end
  end

  // Driver: one request; poke pulses start and scrambles data mid-run
  task automatic request(input logic [W-1:0] word, input string tag, input bit poke);
    item_t it;
    @(negedge clk);
    din   = word;
    start = 1'b1;
    it.exp_cnt = ones_in(word);
    it.t0      = cyc;
    it.exp_lat = 3 + span_of(word);
    it.tag     = tag;
    sb.push_back(it);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    din = ~word;
    if (poke) begin
      start = 1'b1;
      din   = word ^ 8'h5A;
      @(negedge clk);
      start = 1'b0;
      din   = 8'hFF;
    end
    wait (sb.size() == 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL R4 watchdog actual=timeout expected=done");
      summary();
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] lcg;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1", int'(done), 0);
    check(cnt == '0, "R1", int'(cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && cnt == '0, "R1", int'(done), 0);

    // R2: long idle with start low, monitor flags any done
    repeat (20) @(negedge clk);

    request(8'h00, "R7", 1'b0);
    request(8'hFF, "R10", 1'b0);
    request(8'h01, "R3", 1'b0);
    request(8'h80, "R3", 1'b0);
    request(8'hA5, "R3", 1'b0);
    // R9: issued in the cycle right after the previous report
    request(8'h3C, "R9", 1'b0);
    request(8'h10, "R8", 1'b1);
    request(8'h00, "R8", 1'b1);
    request(8'hFE, "R8", 1'b1);

    lcg = 8'h37;
    for (int k = 0; k < 12; k++) begin
      lcg = lcg * 8'd29 + 8'd71;
      request(lcg, "R3", k[0]);
    end

    repeat (12) @(negedge clk);
    check(sb.size() == 0, "R8", sb.size(), 0);
    check(done == 1'b0, "R2", int'(done), 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule